// File: doc/BRIEF.md
# Prescaled Timer Counter

This block is a 16-bit timer/counter. A clock divider in front of it picks one of seven division ratios, from 1 to 1024. The counter counts up from zero to a programmable top value, or down from that top value to zero. At the end of each pass it wraps and raises a one-clock overflow or underflow flag.

A separate event input can advance the counter directly. In that mode the divider is bypassed and held.

A synchronization mode decides what happens at the end of a pass:
- The counter may wrap on the very next raw clock edge, with the divider left free-running.
- It may wrap on the next divided tick.
- It may wrap on the next raw edge and restart the divider from zero at the same time.

In one-shot mode the counter stops after its first wrap. Each channel has two parts:
- A capture register that snapshots the count on a strobe, when that channel's capture is enabled.
- A waveform output that toggles on every wrap and can be inverted per channel.

Control is by plain level ports standing in for a register file: enable, software reset, direction, one-shot, divider select, sync mode, event mode, top value and a count-load strobe.

Top module: `ptc_timer`

## Requirements
- R1: After `rst` or a `swrst_i` cycle, the following hold. The count is 0. The divider is 0 and the one-shot stop is cleared. Both flags are 0. Every capture register is 0. Every waveform output equals its `inv_en_i` bit.
- R2: `psc_sel_i` sets the divide ratio: 0→1, 1→2, 2→4, 3→8, 4→64, 5→256, 6→1024, 7→1024. Counting up from a fresh reset in tick-sync mode, the count first becomes 1 on exactly the ratio-th clock edge.
- R3: Counting up (`dir_down_i`=0), a count equal to `top_i` wraps to 0. In the clock after the wrap, `ovf_o` is 1 for one cycle.
- R4: Counting down (`dir_down_i`=1), a count of 0 wraps to `top_i`. In the clock after the wrap, `unf_o` is 1 for one cycle.
- R5: `sync_mode_i`=0 makes a count at its end value wrap on the next raw clock edge. The divider keeps its phase.
- R6: `sync_mode_i`=1 or 3 makes a count at its end value wrap only on the next divided tick.
- R7: `sync_mode_i`=2 makes a count at its end value wrap on the next raw clock edge. On that same edge the divider is cleared to 0.
- R8: With `evt_mode_i`=1, each clock with `evt_i`=1 moves the count one step, the divider is ignored, and clocks without an event leave the count unchanged.
- R9: With `one_shot_i`=1, the count stops at its wrapped value after the first wrap. A count load clears the stop.
- R10: While `en_i`=0 the count and divider hold. A `cnt_wr_i` pulse while disabled loads `cnt_wdata_i`. A `cnt_wr_i` pulse while enabled is ignored.
- R11: A clock with `cap_strobe_i[c]` and `cap_en_i[c]` both 1 copies the count held before that edge into capture register `c`. With `cap_en_i[c]`=0 the register is unchanged.
- R12: Each wrap toggles every channel's waveform state. `wave_o[c]` is that state XOR `inv_en_i[c]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Raw counting clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable |
| swrst_i | input | 1 | Software reset, same effect as `rst` |
| dir_down_i | input | 1 | 1 = count down from top |
| one_shot_i | input | 1 | Stop after first wrap |
| psc_sel_i | input | 3 | Divide-ratio select |
| sync_mode_i | input | 2 | Wrap/divider behaviour at the end value |
| evt_mode_i | input | 1 | Count events instead of divided ticks |
| evt_i | input | 1 | Event pulse |
| top_i | input | CNT_W | Top value |
| cnt_wr_i | input | 1 | Count load strobe |
| cnt_wdata_i | input | CNT_W | Count load value |
| cap_en_i | input | NUM_CH | Per-channel capture enable |
| cap_strobe_i | input | NUM_CH | Per-channel capture strobe |
| inv_en_i | input | NUM_CH | Per-channel waveform invert |
| count_o | output | CNT_W | Current count |
| ovf_o | output | 1 | Overflow pulse |
| unf_o | output | 1 | Underflow pulse |
| cap_o | output | NUM_CH*CNT_W | Capture registers, channel 0 in the low bits |
| wave_o | output | NUM_CH | Waveform outputs |

## Verification
The bench builds the block with its defaults, CNT_W=16 and NUM_CH=2. Two channels let one test show an enabled capture next to a disabled one, and a plain output next to an inverted one.

Small `top_i` values of 1 to 5 bring wraps, one-shot stops and flag pulses within a few cycles. A divide ratio of 4 is long enough to tell the three sync modes apart by the exact edge on which the count wraps and resumes.

The largest ratio, 1024, costs only about a thousand cycles, so every select code is swept.

// File: rtl/ptc_pkg.sv
package ptc_pkg;

    localparam int PSC_W = 10;

    typedef enum logic [1:0] {
        SYNC_RAW     = 2'd0,
        SYNC_TICK    = 2'd1,
        SYNC_RESTART = 2'd2,
        SYNC_TICK2   = 2'd3
    } sync_e;

    typedef struct packed {
        logic ovf;
        logic unf;
    } wrap_flags_t;

    // terminal value of the divider for each select code
    function automatic logic [PSC_W-1:0] psc_limit(input logic [2:0] sel);
        case (sel)
            3'd0:    return PSC_W'(0);
            3'd1:    return PSC_W'(1);
            3'd2:    return PSC_W'(3);
            3'd3:    return PSC_W'(7);
            3'd4:    return PSC_W'(63);
            3'd5:    return PSC_W'(255);
            default: return PSC_W'(1023);
        endcase
    endfunction

    function automatic logic wraps_on_raw(input sync_e m);
        return (m == SYNC_RAW) || (m == SYNC_RESTART);
    endfunction

endpackage

// File: rtl/ptc_prescaler.sv
module ptc_prescaler
    import ptc_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       clr,
    input  logic       run,
    input  logic       restart,
    input  logic [2:0] sel,
    output logic       tick
);
    logic [PSC_W-1:0] div_q;
    logic [PSC_W-1:0] limit;

    assign limit = psc_limit(sel);
    assign tick  = run && (div_q >= limit);

    always_ff @(posedge clk) begin
        if (rst || clr || restart) begin
            div_q <= '0;
        end else if (run) begin
            if (tick) div_q <= '0;
            else      div_q <= div_q + 1'b1;
        end
    end
endmodule

// File: rtl/ptc_counter.sv
module ptc_counter
    import ptc_pkg::*;
#(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             en,
    input  logic             dir_down,
    input  logic             one_shot,
    input  logic             evt_mode,
    input  logic             evt,
    input  logic             tick,
    input  sync_e            sync_mode,
    input  logic [CNT_W-1:0] top,
    input  logic             wr,
    input  logic [CNT_W-1:0] wdata,
    output logic [CNT_W-1:0] cnt,
    output wrap_flags_t      flags,
    output logic             wrap,
    output logic             active
);
    logic [CNT_W-1:0] cnt_q;
    logic             stop_q;
    wrap_flags_t      flags_q;
    logic             at_end;
    logic             step;

    assign active = en && !stop_q;
    assign at_end = dir_down ? (cnt_q == '0) : (cnt_q == top);
    assign step   = evt_mode ? evt : tick;
    assign wrap   = active && at_end &&
                    (step || (!evt_mode && wraps_on_raw(sync_mode)));

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt_q   <= '0;
            stop_q  <= 1'b0;
            flags_q <= '0;
        end else begin
            flags_q.ovf <= wrap && !dir_down;
            flags_q.unf <= wrap && dir_down;
            if (!en && wr) begin
                cnt_q  <= wdata;
                stop_q <= 1'b0;
            end else if (wrap) begin
                cnt_q <= dir_down ? top : '0;
                if (one_shot) stop_q <= 1'b1;
            end else if (active && step) begin
                cnt_q <= dir_down ? cnt_q - 1'b1 : cnt_q + 1'b1;
            end
        end
    end

    assign cnt   = cnt_q;
    assign flags = flags_q;
endmodule

// File: rtl/ptc_channel.sv
module ptc_channel #(
    parameter int CNT_W = 16
)(
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             cap_en,
    input  logic             strobe,
    input  logic             inv,
    input  logic             wrap,
    input  logic [CNT_W-1:0] cnt,
    output logic [CNT_W-1:0] cap,
    output logic             wave
);
    logic [CNT_W-1:0] cap_q;
    logic             tog_q;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cap_q <= '0;
            tog_q <= 1'b0;
        end else begin
            if (cap_en && strobe) cap_q <= cnt;
            if (wrap)             tog_q <= ~tog_q;
        end
    end

    assign cap  = cap_q;
    assign wave = tog_q ^ inv;
endmodule

// File: rtl/ptc_timer.sv
module ptc_timer
    import ptc_pkg::*;
#(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
)(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en_i,
    input  logic                    swrst_i,
    input  logic                    dir_down_i,
    input  logic                    one_shot_i,
    input  logic [2:0]              psc_sel_i,
    input  logic [1:0]              sync_mode_i,
    input  logic                    evt_mode_i,
    input  logic                    evt_i,
    input  logic [CNT_W-1:0]        top_i,
    input  logic                    cnt_wr_i,
    input  logic [CNT_W-1:0]        cnt_wdata_i,
    input  logic [NUM_CH-1:0]       cap_en_i,
    input  logic [NUM_CH-1:0]       cap_strobe_i,
    input  logic [NUM_CH-1:0]       inv_en_i,
    output logic [CNT_W-1:0]        count_o,
    output logic                    ovf_o,
    output logic                    unf_o,
    output logic [NUM_CH*CNT_W-1:0] cap_o,
    output logic [NUM_CH-1:0]       wave_o
);
    sync_e       sync_mode;
    logic        tick;
    logic        wrap;
    logic        active;
    wrap_flags_t flags;

    assign sync_mode = sync_e'(sync_mode_i);

    ptc_prescaler u_psc (
        .clk     (clk),
        .rst     (rst),
        .clr     (swrst_i),
        .run     (active && !evt_mode_i),
        .restart (wrap && (sync_mode == SYNC_RESTART) && !evt_mode_i),
        .sel     (psc_sel_i),
        .tick    (tick)
    );

    ptc_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk       (clk),
        .rst       (rst),
        .clr       (swrst_i),
        .en        (en_i),
        .dir_down  (dir_down_i),
        .one_shot  (one_shot_i),
        .evt_mode  (evt_mode_i),
        .evt       (evt_i),
        .tick      (tick),
        .sync_mode (sync_mode),
        .top       (top_i),
        .wr        (cnt_wr_i),
        .wdata     (cnt_wdata_i),
        .cnt       (count_o),
        .flags     (flags),
        .wrap      (wrap),
        .active    (active)
    );

    assign ovf_o = flags.ovf;
    assign unf_o = flags.unf;

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        ptc_channel #(.CNT_W(CNT_W)) u_ch (
            .clk    (clk),
            .rst    (rst),
            .clr    (swrst_i),
            .cap_en (cap_en_i[c]),
            .strobe (cap_strobe_i[c]),
            .inv    (inv_en_i[c]),
            .wrap   (wrap),
            .cnt    (count_o),
            .cap    (cap_o[c*CNT_W +: CNT_W]),
            .wave   (wave_o[c])
        );
    end
endmodule

// File: rtl/ptc_checker.sv
module ptc_checker #(
    parameter int CNT_W  = 16,
    parameter int NUM_CH = 2
)(
    input logic                    clk,
    input logic                    rst,
    input logic                    en_i,
    input logic                    swrst_i,
    input logic                    evt_mode_i,
    input logic                    evt_i,
    input logic [CNT_W-1:0]        top_i,
    input logic                    cnt_wr_i,
    input logic [NUM_CH-1:0]       cap_en_i,
    input logic [NUM_CH-1:0]       cap_strobe_i,
    input logic [NUM_CH-1:0]       inv_en_i,
    input logic [CNT_W-1:0]        count_o,
    input logic                    ovf_o,
    input logic                    unf_o,
    input logic [NUM_CH*CNT_W-1:0] cap_o,
    input logic [NUM_CH-1:0]       wave_o
);
    p_flags_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(ovf_o && unf_o));

    p_ovf_zero_r3: assert property (@(posedge clk) disable iff (rst)
        ovf_o |-> count_o == '0);

    p_unf_top_r4: assert property (@(posedge clk) disable iff (rst)
        unf_o |-> count_o == $past(top_i));

    p_hold_off_r10: assert property (@(posedge clk) disable iff (rst)
        (!en_i && !cnt_wr_i && !swrst_i) |=> count_o == $past(count_o));

    p_evt_idle_r8: assert property (@(posedge clk) disable iff (rst)
        (evt_mode_i && !evt_i && !cnt_wr_i && !swrst_i) |=> count_o == $past(count_o));

    p_wave_flip_r12: assert property (@(posedge clk) disable iff (rst)
        ((ovf_o || unf_o) && inv_en_i == $past(inv_en_i)) |-> wave_o != $past(wave_o));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        p_cap_take_r11: assert property (@(posedge clk) disable iff (rst)
            (cap_en_i[c] && cap_strobe_i[c] && !swrst_i)
            |=> cap_o[c*CNT_W +: CNT_W] == $past(count_o));
        p_cap_keep_r11: assert property (@(posedge clk) disable iff (rst)
            (!(cap_en_i[c] && cap_strobe_i[c]) && !swrst_i)
            |=> cap_o[c*CNT_W +: CNT_W] == $past(cap_o[c*CNT_W +: CNT_W]));
    end
endmodule

bind ptc_timer ptc_checker #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .en_i         (en_i),
    .swrst_i      (swrst_i),
    .evt_mode_i   (evt_mode_i),
    .evt_i        (evt_i),
    .top_i        (top_i),
    .cnt_wr_i     (cnt_wr_i),
    .cap_en_i     (cap_en_i),
    .cap_strobe_i (cap_strobe_i),
    .inv_en_i     (inv_en_i),
    .count_o      (count_o),
    .ovf_o        (ovf_o),
    .unf_o        (unf_o),
    .cap_o        (cap_o),
    .wave_o       (wave_o)
);

// File: tb/ptc_timer_tb.sv
`timescale 1ns/1ps
module ptc_timer_tb;
    localparam int CNT_W  = 16;
    localparam int NUM_CH = 2;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    en_i = 1'b0;
    logic                    swrst_i = 1'b0;
    logic                    dir_down_i = 1'b0;
    logic                    one_shot_i = 1'b0;
    logic [2:0]              psc_sel_i = '0;
    logic [1:0]              sync_mode_i = '0;
    logic                    evt_mode_i = 1'b0;
    logic                    evt_i = 1'b0;
    logic [CNT_W-1:0]        top_i = '1;
    logic                    cnt_wr_i = 1'b0;
    logic [CNT_W-1:0]        cnt_wdata_i = '0;
    logic [NUM_CH-1:0]       cap_en_i = '0;
    logic [NUM_CH-1:0]       cap_strobe_i = '0;
    logic [NUM_CH-1:0]       inv_en_i = '0;
    logic [CNT_W-1:0]        count_o;
    logic                    ovf_o;
    logic                    unf_o;
    logic [NUM_CH*CNT_W-1:0] cap_o;
    logic [NUM_CH-1:0]       wave_o;

    int n_checks = 0;
    int n_fails  = 0;
    bit done     = 1'b0;

    always #5 clk = ~clk;

    ptc_timer #(.CNT_W(CNT_W), .NUM_CH(NUM_CH)) u_dut (
        .clk(clk), .rst(rst), .en_i(en_i), .swrst_i(swrst_i),
        .dir_down_i(dir_down_i), .one_shot_i(one_shot_i),
        .psc_sel_i(psc_sel_i), .sync_mode_i(sync_mode_i),
        .evt_mode_i(evt_mode_i), .evt_i(evt_i), .top_i(top_i),
        .cnt_wr_i(cnt_wr_i), .cnt_wdata_i(cnt_wdata_i),
        .cap_en_i(cap_en_i), .cap_strobe_i(cap_strobe_i), .inv_en_i(inv_en_i),
        .count_o(count_o), .ovf_o(ovf_o), .unf_o(unf_o),
        .cap_o(cap_o), .wave_o(wave_o)
    );

    task automatic check(input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic edges(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic soft_reset();
        en_i = 1'b0;
        swrst_i = 1'b1;
        edges(1);
        swrst_i = 1'b0;
    endtask

    // R1: state after reset and after a software reset
    task automatic t_reset();
        inv_en_i = 2'b10;
        edges(1);
        check("R1", "count after rst", count_o, 0);
        check("R1", "flags after rst", {ovf_o, unf_o}, 0);
        check("R1", "capture after rst", cap_o, 0);
        check("R1", "wave after rst", wave_o, 2'b10);
        top_i = 16'd9; en_i = 1'b1;
        edges(4);
        soft_reset();
        check("R1", "count after swrst", count_o, 0);
        check("R1", "wave after swrst", wave_o, 2'b10);
        inv_en_i = 2'b00;
    endtask

    // R2: every divider select code
    task automatic t_ratios();
        for (int s = 0; s < 8; s++) begin
            int ratio;
            case (s)
                0: ratio = 1;   1: ratio = 2;   2: ratio = 4;   3: ratio = 8;
                4: ratio = 64;  5: ratio = 256; default: ratio = 1024;
            endcase
            soft_reset();
            top_i = '1; sync_mode_i = 2'd1; psc_sel_i = 3'(s); en_i = 1'b1;
            edges(ratio - 1);
            check("R2", $sformatf("sel %0d before tick", s), count_o, 0);
            edges(1);
            check("R2", $sformatf("sel %0d on tick", s), count_o, 1);
        end
    endtask

    // R3: up count wraps with overflow pulse
    task automatic t_up();
        soft_reset();
        top_i = 16'd5; psc_sel_i = 3'd0; sync_mode_i = 2'd0; en_i = 1'b1;
        edges(5);
        check("R3", "count at top", count_o, 5);
        check("R3", "no ovf at top", ovf_o, 0);
        edges(1);
        check("R3", "wrapped count", count_o, 0);
        check("R3", "ovf pulse", ovf_o, 1);
        edges(1);
        check("R3", "count after wrap", count_o, 1);
        check("R3", "ovf one cycle", ovf_o, 0);
    endtask

    // R4: down count wraps with underflow pulse
    task automatic t_down();
        soft_reset();
        top_i = 16'd3; dir_down_i = 1'b1; psc_sel_i = 3'd0; en_i = 1'b1;
        edges(1);
        check("R4", "first underflow to top", count_o, 3);
        check("R4", "unf pulse", unf_o, 1);
        edges(1);
        check("R4", "count down", count_o, 2);
        check("R4", "unf one cycle", unf_o, 0);
        edges(3);
        check("R4", "second wrap", count_o, 3);
        check("R4", "second unf", unf_o, 1);
        dir_down_i = 1'b0;
    endtask

    // R5/R6/R7: sync modes at divide ratio 4, top 2
    task automatic t_sync(input logic [1:0] mode);
        soft_reset();
        top_i = 16'd2; psc_sel_i = 3'd2; sync_mode_i = mode; en_i = 1'b1;
        edges(8);
        check("R5", "reached top", count_o, 2);
        edges(1);
        if (mode == 2'd1) begin
            check("R6", "tick mode holds top", count_o, 2);
            edges(3);
            check("R6", "tick mode wraps on tick", count_o, 0);
            check("R6", "tick mode ovf", ovf_o, 1);
        end else begin
            check(mode == 2'd0 ? "R5" : "R7", "raw wrap", count_o, 0);
            check(mode == 2'd0 ? "R5" : "R7", "raw ovf", ovf_o, 1);
            edges(3);
            if (mode == 2'd0)
                check("R5", "divider kept phase", count_o, 1);
            else begin
                check("R7", "divider restarted", count_o, 0);
                edges(1);
                check("R7", "tick after restart", count_o, 1);
            end
        end
    endtask

    // R8 and R10: events, hold while disabled, load rules
    task automatic t_events_and_load();
        soft_reset();
        top_i = '1; psc_sel_i = 3'd6; evt_mode_i = 1'b1; en_i = 1'b1;
        for (int k = 0; k < 3; k++) begin
            evt_i = 1'b1; edges(1);
            evt_i = 1'b0; edges(2);
        end
        check("R8", "three events", count_o, 3);
        edges(5);
        check("R8", "no event no step", count_o, 3);
        en_i = 1'b0;
        edges(4);
        check("R10", "hold while disabled", count_o, 3);
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'h1234; edges(1); cnt_wr_i = 1'b0;
        check("R10", "load while disabled", count_o, 16'h1234);
        en_i = 1'b1;
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'h0077; edges(1); cnt_wr_i = 1'b0;
        check("R10", "load ignored while enabled", count_o, 16'h1234);
        evt_mode_i = 1'b0;
    endtask

    // R9: one-shot stop and restart by load
    task automatic t_one_shot();
        soft_reset();
        top_i = 16'd2; psc_sel_i = 3'd0; sync_mode_i = 2'd0; one_shot_i = 1'b1;
        en_i = 1'b1;
        edges(3);
        check("R9", "first wrap", count_o, 0);
        check("R9", "first wrap ovf", ovf_o, 1);
        edges(3);
        check("R9", "stopped after wrap", count_o, 0);
        check("R9", "no further ovf", ovf_o, 0);
        en_i = 1'b0;
        cnt_wr_i = 1'b1; cnt_wdata_i = 16'd1; edges(1); cnt_wr_i = 1'b0;
        en_i = 1'b1;
        edges(1);
        check("R9", "runs again after load", count_o, 2);
        one_shot_i = 1'b0;
    endtask

    // R11 and R12: capture gating and waveform toggling
    task automatic t_channels();
        inv_en_i = 2'b10;
        soft_reset();
        top_i = 16'd1; psc_sel_i = 3'd0; sync_mode_i = 2'd0; en_i = 1'b1;
        edges(2);
        check("R12", "wave after first wrap", wave_o, 2'b01);
        edges(1);
        check("R11", "count before capture", count_o, 1);
        cap_en_i = 2'b01; cap_strobe_i = 2'b11;
        edges(1);
        cap_strobe_i = 2'b00;
        check("R11", "ch0 captured", cap_o[CNT_W-1:0], 1);
        check("R11", "ch1 gated off", cap_o[2*CNT_W-1:CNT_W], 0);
        check("R12", "wave after second wrap", wave_o, 2'b10);
        inv_en_i = 2'b00;
    endtask

    initial begin
        edges(2);
        rst = 1'b0;
        t_reset();
        t_up();
        t_down();
        t_sync(2'd0);
        t_sync(2'd1);
        t_sync(2'd2);
        t_events_and_load();
        t_one_shot();
        t_channels();
        t_ratios();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fails++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
            $finish;
        end
    end
endmodule